// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs exception entry and return for a simple 32-bit in-order core. Each cycle it looks at the pipeline's requests: machine check, non-maskable debug, external interrupt and synchronous faults. The synchronous faults arrive with their own cause code. It picks the single highest-priority request that may be taken. For that request it writes the restart address into save register 0 (`srr0`). It writes the old machine state, together with a cause code, into save register 1 (`srr1`). It then hands the pipeline a new machine state, a flush pulse and a handler fetch address.

The handler address is a table base ORed with the cause code shifted left by eight bits. The table base is all zeros when the prefix bit of the machine state is 0, and 0xFFF0_0000 when it is 1.

On entry, the recoverable flag of the machine state is saved into `srr1` and then cleared in the new state. A handler that is itself interrupted can therefore tell from the saved flag whether the earlier saved state survived. A return request writes the contents of `srr1` back into the machine state and redirects fetch to `srr0`.

The machine state register itself lives in the pipeline. The block reads it on `msr_in` and proposes a new value with a one-cycle write pulse.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After an active-low reset, `srr0`, `srr1`, `redir_vld`, `msr_we` and `flush` are all zero.
- R2: Priority is fixed. Machine check comes first, then debug, then external, then synchronous. Exactly one request is taken per cycle. Its cause code is written to `srr1[3:0]`: machine check 0x2, debug 0xE, external 0x5, synchronous `sync_code`.
- R3: An external request is ignored while the enable bit `msr_in[15]` is 0. It then yields no redirect and leaves `srr0`/`srr1` unchanged.
- R4: For machine check, debug and external requests, `srr0` receives `cur_pc`. For a synchronous request, `srr0` receives `cur_pc` when `sync_after` is 0 and `nxt_pc` when it is 1.
- R5: On entry, `srr1[31:4]` receives `msr_in[31:4]`. This includes the recoverable flag at bit 4.
- R6: On entry, `msr_we` pulses and `msr_nxt` equals `msr_in` with bit 4 (recoverable), bit 14 (privilege) and bit 15 (external enable) cleared.
- R7: The handler address `redir_pc` is the base ORed with code<<8. The base is 0x0000_0000 if `msr_in[6]` is 0 and 0xFFF0_0000 if it is 1.
- R8: Every entry gives a `flush` pulse in the same cycle as `redir_vld` and the save-register update. A return never raises `flush`.
- R9: A return request with nothing taken redirects to the current `srr0`. It sets `msr_nxt` to `{srr1[31:4], msr_in[3:0]}` and leaves both save registers unchanged.
- R10: When a return and a takeable exception arrive in the same cycle, the exception is taken and the return is dropped.
- R11: Machine check and debug are taken even while the recoverable flag is 0. In that case `srr1[4]` records 0.

All outputs are registered: a request sampled at a clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_mchk | input | 1 | Machine check request |
| req_dbg | input | 1 | Non-maskable debug request |
| req_ext | input | 1 | External interrupt request |
| req_sync | input | 1 | Synchronous fault request |
| sync_code | input | 4 | Cause code of the synchronous fault |
| sync_after | input | 1 | Synchronous restart at next instruction |
| cur_pc | input | 32 | Address of the current instruction |
| nxt_pc | input | 32 | Address of the following instruction |
| msr_in | input | 32 | Current machine state |
| rfi_req | input | 1 | Return-from-exception request |
| redir_vld | output | 1 | Fetch redirect pulse |
| redir_pc | output | 32 | Redirect target |
| msr_we | output | 1 | Machine state write pulse |
| msr_nxt | output | 32 | New machine state |
| flush | output | 1 | Pipeline flush pulse on entry |
| srr0 | output | 32 | Save register 0: restart address |
| srr1 | output | 32 | Save register 1: saved state and cause |

## Verification
Single requests are applied with both prefix settings and both `sync_after` settings, which separates the two table bases and the two restart addresses. Overlapping request sets are applied next. All four at once, debug with lower ones, and external with synchronous under each enable setting show whether the priority order and the masking of external requests are right. A machine check with the recoverable flag at 0, followed by a return, shows that the flag is saved as 0 and restored as 0. A return in the same cycle as a fault shows that the exception wins. Idle and masked cycles confirm that nothing is redirected and the save registers keep their values.

// File: rtl/exc_pkg.sv
// Shared constants for the exception entry controller.
// Assumes a 32-bit machine state with the field positions below.
package exc_pkg;
    localparam int RI_BIT = 4;   // recoverable flag
    localparam int IP_BIT = 6;   // vector table prefix
    localparam int PR_BIT = 14;  // privilege mode
    localparam int EE_BIT = 15;  // external interrupt enable

    localparam logic [3:0] CODE_MCHK = 4'h2;
    localparam logic [3:0] CODE_DBG  = 4'hE;
    localparam logic [3:0] CODE_EXT  = 4'h5;

    localparam logic [31:0] VEC_HI_BASE = 32'hFFF0_0000;

    // Cause code of a request source, index 0 being the most urgent.
    function automatic logic [3:0] src_code(input int idx, input logic [3:0] sync_c);
        case (idx)
            0:       src_code = CODE_MCHK;
            1:       src_code = CODE_DBG;
            2:       src_code = CODE_EXT;
            default: src_code = sync_c;
        endcase
    endfunction
endpackage

// File: rtl/exc_arb.sv
// Fixed-priority selector of exception sources.
// req[0] is the most urgent. Sources below ASYNC_N are asynchronous.
// Assumes external masking has already been applied to the request.
module exc_arb #(
    parameter int NSRC    = 4,
    parameter int ASYNC_N = 3,
    parameter int CODE_W  = 4
) (
    input  logic [NSRC-1:0]   req,
    input  logic [CODE_W-1:0] sync_code,
    output logic              take,
    output logic              is_async,
    output logic [CODE_W-1:0] code
);
    // Walk from lowest to highest priority so the most urgent wins.
    always_comb begin
        take     = |req;
        is_async = 1'b0;
        code     = sync_code;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                code     = exc_pkg::src_code(i, sync_code);
                is_async = (i < ASYNC_N);
            end
        end
    end
endmodule

// File: rtl/exc_vec.sv
// Handler address generator: table base selected by the prefix bit,
// ORed with the cause code placed at bit SHIFT.
// Assumes the code field stays below the base's lowest set bit.
module exc_vec #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 4,
    parameter int SHIFT  = 8
) (
    input  logic              prefix,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   vec_addr
);
    localparam int PAD = XLEN - CODE_W - SHIFT;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Select the table base and place the offset.
    always_comb begin
        base     = prefix ? exc_pkg::VEC_HI_BASE : '0;
        offset   = {{PAD{1'b0}}, code, {SHIFT{1'b0}}};
        vec_addr = base | offset;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry/return controller.
// Arbitrates requests, fills the save registers, produces the new
// machine state, the flush pulse and the fetch redirect. All outputs
// are registered. Assumes the pipeline holds the machine state and
// applies msr_nxt when msr_we pulses.
module exc_entry_ctrl #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 4,
    parameter int SHIFT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_mchk,
    input  logic              req_dbg,
    input  logic              req_ext,
    input  logic              req_sync,
    input  logic [CODE_W-1:0] sync_code,
    input  logic              sync_after,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   nxt_pc,
    input  logic [XLEN-1:0]   msr_in,
    input  logic              rfi_req,
    output logic              redir_vld,
    output logic [XLEN-1:0]   redir_pc,
    output logic              msr_we,
    output logic [XLEN-1:0]   msr_nxt,
    output logic              flush,
    output logic [XLEN-1:0]   srr0,
    output logic [XLEN-1:0]   srr1
);
    import exc_pkg::*;

    localparam int NSRC = 4;
    localparam logic [XLEN-1:0] CLR_MASK =
        ~((XLEN'(1) << RI_BIT) | (XLEN'(1) << PR_BIT) | (XLEN'(1) << EE_BIT));

    logic [NSRC-1:0]   req_vec;
    logic              take;
    logic              is_async;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   vec_addr;
    logic [XLEN-1:0]   save_pc;
    logic [XLEN-1:0]   srr1_new;
    logic [XLEN-1:0]   msr_entry;
    logic [XLEN-1:0]   msr_ret;
    logic              rfi_go;

    // Gather requests in priority order, masking external by its enable.
    always_comb begin
        req_vec = {req_sync, req_ext & msr_in[EE_BIT], req_dbg, req_mchk};
    end

    exc_arb #(.NSRC(NSRC), .ASYNC_N(3), .CODE_W(CODE_W)) u_arb (
        .req       (req_vec),
        .sync_code (sync_code),
        .take      (take),
        .is_async  (is_async),
        .code      (code)
    );

    exc_vec #(.XLEN(XLEN), .CODE_W(CODE_W), .SHIFT(SHIFT)) u_vec (
        .prefix   (msr_in[IP_BIT]),
        .code     (code),
        .vec_addr (vec_addr)
    );

    // Compose save values, entry state and return state.
    always_comb begin
        save_pc   = (is_async || !sync_after) ? cur_pc : nxt_pc;
        srr1_new  = {msr_in[XLEN-1:CODE_W], code};
        msr_entry = msr_in & CLR_MASK;
        msr_ret   = {srr1[XLEN-1:CODE_W], msr_in[CODE_W-1:0]};
        rfi_go    = rfi_req && !take;
    end

    // Register save registers and the one-cycle redirect outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srr0      <= '0;
            srr1      <= '0;
            redir_vld <= 1'b0;
            redir_pc  <= '0;
            msr_we    <= 1'b0;
            msr_nxt   <= '0;
            flush     <= 1'b0;
        end else begin
            redir_vld <= take || rfi_go;
            msr_we    <= take || rfi_go;
            flush     <= take;
            if (take) begin
                srr0     <= save_pc;
                srr1     <= srr1_new;
                redir_pc <= vec_addr;
                msr_nxt  <= msr_entry;
            end else if (rfi_go) begin
                redir_pc <= srr0;
                msr_nxt  <= msr_ret;
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for the exception entry controller, bound to the top.
module exc_entry_chk #(
    parameter int XLEN  = 32,
    parameter int SHIFT = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_mchk,
    input logic            req_dbg,
    input logic            req_ext,
    input logic            req_sync,
    input logic            rfi_req,
    input logic            msr_ri,
    input logic            msr_ip,
    input logic            msr_ee,
    input logic            redir_vld,
    input logic [XLEN-1:0] redir_pc,
    input logic            msr_we,
    input logic            nxt_ri,
    input logic            nxt_ee,
    input logic            nxt_pr,
    input logic            flush,
    input logic [XLEN-1:0] srr0,
    input logic            srr1_ri
);
    // R8
    flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (redir_vld && msr_we));

    // R6
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!nxt_ri && !nxt_ee && !nxt_pr));

    // R5
    ri_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (srr1_ri == $past(msr_ri)));

    // R7
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (redir_pc[SHIFT-1:0] == '0));

    // R7
    vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> ((redir_pc[XLEN-1:20] != '0) == $past(msr_ip)));

    // R3
    ext_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ext && !msr_ee && !req_mchk && !req_dbg && !req_sync && !rfi_req)
        |=> !redir_vld);

    // R9
    rfi_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_req && !req_mchk && !req_dbg && !req_sync && !(req_ext && msr_ee))
        |=> (redir_vld && !flush && redir_pc == $past(srr0)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .SHIFT(SHIFT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_mchk  (req_mchk),
    .req_dbg   (req_dbg),
    .req_ext   (req_ext),
    .req_sync  (req_sync),
    .rfi_req   (rfi_req),
    .msr_ri    (msr_in[exc_pkg::RI_BIT]),
    .msr_ip    (msr_in[exc_pkg::IP_BIT]),
    .msr_ee    (msr_in[exc_pkg::EE_BIT]),
    .redir_vld (redir_vld),
    .redir_pc  (redir_pc),
    .msr_we    (msr_we),
    .nxt_ri    (msr_nxt[exc_pkg::RI_BIT]),
    .nxt_ee    (msr_nxt[exc_pkg::EE_BIT]),
    .nxt_pr    (msr_nxt[exc_pkg::PR_BIT]),
    .flush     (flush),
    .srr0      (srr0),
    .srr1_ri   (srr1[exc_pkg::RI_BIT])
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    localparam logic [31:0] M_RI = 32'h1 << 4;
    localparam logic [31:0] M_IP = 32'h1 << 6;
    localparam logic [31:0] M_PR = 32'h1 << 14;
    localparam logic [31:0] M_EE = 32'h1 << 15;

    typedef struct {
        string       tag;
        logic        vld;
        logic        fl;
        logic [31:0] pc;
        logic [31:0] msr;
        logic [31:0] s0;
        logic [31:0] s1;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_mchk = 0, req_dbg = 0, req_ext = 0, req_sync = 0;
    logic [3:0] sync_code = '0;
    logic sync_after = 0, rfi_req = 0;
    logic [31:0] cur_pc = '0, nxt_pc = '0, msr_in = '0;
    logic redir_vld, msr_we, flush;
    logic [31:0] redir_pc, msr_nxt, srr0, srr1;

    int total = 0;
    int bad = 0;
    exp_t q[$];
    logic [31:0] m_s0 = '0, m_s1 = '0;
    bit finished = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_mchk(req_mchk), .req_dbg(req_dbg),
        .req_ext(req_ext), .req_sync(req_sync), .sync_code(sync_code),
        .sync_after(sync_after), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
        .msr_in(msr_in), .rfi_req(rfi_req), .redir_vld(redir_vld),
        .redir_pc(redir_pc), .msr_we(msr_we), .msr_nxt(msr_nxt),
        .flush(flush), .srr0(srr0), .srr1(srr1)
    );

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input string tag, input logic mc, input logic db,
                        input logic ex, input logic sy, input logic [3:0] sc,
                        input logic aft, input logic [31:0] cp,
                        input logic [31:0] np, input logic [31:0] m,
                        input logic rf);
        exp_t e;
        logic take;
        logic asy;
        logic [3:0] c;
        @(negedge clk);
        req_mchk = mc; req_dbg = db; req_ext = ex; req_sync = sy;
        sync_code = sc; sync_after = aft; cur_pc = cp; nxt_pc = np;
        msr_in = m; rfi_req = rf;
        take = 1'b1; asy = 1'b1; c = sc;
        if (mc)                c = 4'h2;
        else if (db)           c = 4'hE;
        else if (ex && m[15])  c = 4'h5;
        else if (sy)           asy = 1'b0;
        else                   take = 1'b0;
        e.tag = tag; e.vld = 0; e.fl = 0; e.pc = '0; e.msr = '0;
        if (take) begin
            e.vld = 1; e.fl = 1;
            e.pc  = (m[6] ? 32'hFFF0_0000 : 32'h0) | (32'(c) << 8);
            e.msr = m & ~(M_RI | M_PR | M_EE);
            m_s0  = (asy || !aft) ? cp : np;
            m_s1  = {m[31:4], c};
        end else if (rf) begin
            e.vld = 1;
            e.pc  = m_s0;
            e.msr = {m_s1[31:4], m[3:0]};
        end
        e.s0 = m_s0; e.s1 = m_s1;
        q.push_back(e);
    endtask

    // Monitor: compare one expected item per cycle, after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                logic ok;
                e = q.pop_front();
                total++;
                ok = (redir_vld == e.vld) && (flush == e.fl) && (msr_we == e.vld)
                     && (srr0 == e.s0) && (srr1 == e.s1);
                if (e.vld) ok = ok && (redir_pc == e.pc) && (msr_nxt == e.msr);
                if (!ok) begin
                    bad++;
                    $display("FAIL %s: got vld=%0b fl=%0b pc=%h msr=%h s0=%h s1=%h exp vld=%0b fl=%0b pc=%h msr=%h s0=%h s1=%h",
                             e.tag, redir_vld, flush, redir_pc, msr_nxt, srr0, srr1,
                             e.vld, e.fl, e.pc, e.msr, e.s0, e.s1);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got no end, exp end of sequence");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        total++;
        // R1 reset state
        if (srr0 !== 0 || srr1 !== 0 || redir_vld !== 0 || msr_we !== 0 || flush !== 0) begin
            bad++;
            $display("FAIL R1 reset: got s0=%h s1=%h vld=%0b we=%0b fl=%0b exp all zero",
                     srr0, srr1, redir_vld, msr_we, flush);
        end
        @(negedge clk); rst_n = 1;

        step("R4 R5 R6 R7 sync program low base", 0,0,0,1,4'h7,0, 32'h100, 32'h104, M_RI|M_EE|M_PR|32'h2000, 0);
        step("R4 R7 sync syscall high base after", 0,0,0,1,4'hC,1, 32'h200, 32'h204, M_RI|M_IP|M_EE|32'h1, 0);
        step("R9 return restores", 0,0,0,0,4'h0,0, 32'h0, 32'h0, M_IP|32'h9, 1);
        step("R2 R4 external enabled", 0,0,1,0,4'h0,0, 32'h300, 32'h304, M_RI|M_EE, 0);
        step("R3 external masked", 0,0,1,0,4'h0,0, 32'h400, 32'h404, M_RI, 0);
        step("R2 all four machine check wins", 1,1,1,1,4'h7,1, 32'h500, 32'h504, M_RI|M_EE|M_IP, 0);
        step("R2 debug over ext and sync", 0,1,1,1,4'h6,1, 32'h600, 32'h604, M_RI|M_EE, 0);
        step("R2 ext over sync", 0,0,1,1,4'h6,1, 32'h700, 32'h704, M_EE|M_PR, 0);
        step("R2 R3 sync when ext masked", 0,0,1,1,4'h6,1, 32'h800, 32'h804, M_RI, 0);
        step("R11 machine check with RI clear", 1,0,0,0,4'h0,0, 32'h900, 32'h904, M_EE|M_IP, 0);
        step("R9 R11 return restores RI clear", 0,0,0,0,4'h0,0, 32'h0, 32'h0, M_RI|32'h3, 1);
        step("R10 return and sync same cycle", 0,0,0,1,4'h8,0, 32'hA00, 32'hA04, M_RI|M_EE, 1);
        step("R11 debug with RI clear", 0,1,0,0,4'h0,0, 32'hB00, 32'hB04, 32'h0, 0);
        step("R8 idle no redirect", 0,0,0,0,4'h0,0, 32'hC00, 32'hC04, M_RI|M_EE, 0);
        step("R9 return after debug", 0,0,0,0,4'h0,0, 32'h0, 32'h0, M_EE, 1);
        step("R3 masked ext then idle", 0,0,1,0,4'h0,0, 32'hD00, 32'hD04, M_IP, 0);
        @(negedge clk);
        req_mchk = 0; req_dbg = 0; req_ext = 0; req_sync = 0; rfi_req = 0;
        repeat (3) @(posedge clk);
        #6;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule